// File: doc/BRIEF.md
# Radix Page Table Walker

This block resolves a virtual address to a real address by walking a radix tree of 8-byte entries held in memory. A caller gives a root table base, the root index width and the total address-space width, then pulses `start`. The walker reads one entry per level through a simple request/response port. For every level it checks that the tree geometry is one it supports, and it clears any low bits of a table base that break natural alignment.

A walk ends with a one-cycle `done` pulse. On success it reports the real address, the page size (the address bits left over below the leaf), the raw leaf entry and the address the leaf came from. On failure `fault` is set and a cause code tells a missing entry apart from a bad configuration. Access rights, reference/change updates and the chaining of two translation stages belong to the parent, which holds one walker for each stage.

Top module: `radix_walker`

## Requirements
- R1: At each level the entry address is the table base with its low (index width + 3) bits cleared, plus 8 times the index. The index is the virtual address shifted right by (remaining width − index width) and masked to the index width. `pte_addr` reports the address of the leaf entry.
- R2: A root base or next-level base with bits set below its alignment is used as if those bits were zero. No fault is raised for it.
- R3: Before each read the level geometry is checked. Level 0 needs remaining width 52 and index width 13. Levels 1 and 2 need index width 9. Level 3 needs 9 or 5. Level 4 and deeper are never valid. A failure ends the walk with `fault`=1 and `fault_cause`=2'b10, and no read is made.
- R4: An entry with bit 63 (valid) clear ends the walk with `fault`=1 and `fault_cause`=2'b01.
- R5: After each valid entry, the remaining width drops by the current index width. A valid entry with bit 62 clear is a directory. Its bits [4:0] give the next index width and its bits [55:8] give the next table base.
- R6: A valid entry with bit 62 (leaf) set ends the walk with `fault`=0. `real_addr` takes leaf bits [55:12] at and above the remaining width, and virtual-address bits below it. `leaf_pte` is the raw leaf entry.
- R7: `page_size` reports the remaining width left after the leaf level.
- R8: A `start` pulse seen while `busy` is high is ignored. The running walk finishes unchanged, and no further request or `done` follows it.
- R9: `done` lasts one cycle. `fault_cause` is one-hot when `fault` is set and zero otherwise. After reset `done`, `busy` and `mem_req` are low.
- R10: Each level spends one cycle in its geometry check, which raises `mem_req` for that cycle. The response is consumed in the cycle it arrives. `done` rises on the edge that accepts the leaf or faulting response, or on the edge that ends a failed check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (used only when idle) |
| va | input | 64 | Virtual address to translate |
| root_base | input | 64 | Root table base address |
| root_nls | input | 5 | Root index width |
| total_size | input | 7 | Total address-space width |
| mem_req | output | 1 | Entry read request, one cycle |
| mem_addr | output | 64 | Entry address for the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished, one cycle |
| fault | output | 1 | Walk ended in a fault |
| fault_cause | output | 2 | bit0 missing entry, bit1 bad configuration |
| real_addr | output | 64 | Resolved real address |
| page_size | output | 7 | Page size as a bit count |
| leaf_pte | output | 64 | Raw leaf entry |
| pte_addr | output | 64 | Address of the leaf entry |

## Verification
Once `start` is sampled on edge E0, the check for level k ends on edge E(2k+1). With the bench memory answering one cycle after each request, the response for level k is taken on edge E(2k+2). So `done` is due after E(2L) when the walk ends on read number L, and after E(2k+1) when the geometry check at level k fails. The bench's reference walk works out this edge ahead of time. At every falling edge after a start it compares `done` and `busy` with that schedule, and it checks the result fields only in the cycle where `done` is due. After each walk a few idle cycles confirm that no stray request or completion appears.

// File: rtl/radix_walker.sv
module radix_walker #(
  parameter int AW      = 64,
  parameter int SZW     = 7,
  parameter int NW      = 5,
  parameter int LVLW    = 3,
  parameter int VLD_BIT = 63,
  parameter int LF_BIT  = 62,
  parameter int RPN_LO  = 12,
  parameter int RPN_HI  = 55,
  parameter int NLB_LO  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  va,
  input  logic [AW-1:0]  root_base,
  input  logic [NW-1:0]  root_nls,
  input  logic [SZW-1:0] total_size,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  input  logic           mem_rsp_valid,
  input  logic [AW-1:0]  mem_rsp_data,
  output logic           busy,
  output logic           done,
  output logic           fault,
  output logic [1:0]     fault_cause,
  output logic [AW-1:0]  real_addr,
  output logic [SZW-1:0] page_size,
  output logic [AW-1:0]  leaf_pte,
  output logic [AW-1:0]  pte_addr
);
  localparam logic [AW-1:0] ONE      = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [AW-1:0] RPN_MASK = ((ONE << (RPN_HI+1)) - ONE) & ~((ONE << RPN_LO) - ONE);
  localparam logic [AW-1:0] NLB_MASK = ((ONE << (RPN_HI+1)) - ONE) & ~((ONE << NLB_LO) - ONE);

  typedef enum logic [1:0] {S_IDLE, S_CHK, S_WAIT} st_t;

  function automatic logic [AW-1:0] slot(input logic [AW-1:0] base, input logic [AW-1:0] v,
                                         input logic [SZW-1:0] p, input logic [NW-1:0] n);
    logic [AW-1:0] amask, idx;
    logic [SZW-1:0] sh;
    amask = (ONE << ({1'b0, n} + 6'd3)) - ONE;
    sh    = p - SZW'(n);
    idx   = (v >> sh) & ((ONE << n) - ONE);
    return (base & ~amask) + (idx << 3);
  endfunction

  st_t            st;
  logic [AW-1:0]  va_q, addr_q;
  logic [SZW-1:0] psz_q;
  logic [NW-1:0]  nls_q;
  logic [LVLW-1:0] lvl_q;
  logic           lvl_ok;

  wire [SZW-1:0] new_psz  = psz_q - SZW'(nls_q);
  wire [NW-1:0]  next_nls = mem_rsp_data[NW-1:0];
  wire [AW-1:0]  next_adr = slot(mem_rsp_data & NLB_MASK, va_q, new_psz, next_nls);
  wire [AW-1:0]  off_mask = (ONE << new_psz) - ONE;

  always_comb begin
    case (lvl_q)
      LVLW'(0):       lvl_ok = (psz_q == SZW'(52)) && (nls_q == NW'(13));
      LVLW'(1), LVLW'(2): lvl_ok = (nls_q == NW'(9));
      LVLW'(3):       lvl_ok = (nls_q == NW'(9)) || (nls_q == NW'(5));
      default:        lvl_ok = 1'b0;
    endcase
  end

  assign mem_req  = (st == S_CHK) && lvl_ok;
  assign mem_addr = addr_q;
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; va_q <= '0; addr_q <= '0; psz_q <= '0; nls_q <= '0; lvl_q <= '0;
      done <= 1'b0; fault <= 1'b0; fault_cause <= 2'b00;
      real_addr <= '0; page_size <= '0; leaf_pte <= '0; pte_addr <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          va_q   <= va;
          psz_q  <= total_size;
          nls_q  <= root_nls;
          lvl_q  <= '0;
          addr_q <= slot(root_base, va, total_size, root_nls);
          st     <= S_CHK;
        end
        S_CHK: if (!lvl_ok) begin
          done <= 1'b1; fault <= 1'b1; fault_cause <= 2'b10; st <= S_IDLE;
        end else begin
          st <= S_WAIT;
        end
        S_WAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_data[VLD_BIT]) begin
            done <= 1'b1; fault <= 1'b1; fault_cause <= 2'b01; st <= S_IDLE;
          end else begin
            psz_q <= new_psz;
            if (mem_rsp_data[LF_BIT]) begin
              done        <= 1'b1;
              fault       <= 1'b0;
              fault_cause <= 2'b00;
              real_addr   <= (mem_rsp_data & RPN_MASK & ~off_mask) | (va_q & off_mask);
              page_size   <= new_psz;
              leaf_pte    <= mem_rsp_data;
              pte_addr    <= addr_q;
              st          <= S_IDLE;
            end else begin
              nls_q  <= next_nls;
              addr_q <= next_adr;
              lvl_q  <= lvl_q + LVLW'(1);
              st     <= S_CHK;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_req_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[2:0] == 3'b000);
  p_nopte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_cause[0]) |-> ($past(mem_rsp_valid) && !$past(mem_rsp_data[VLD_BIT])));
  p_leaf_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> ($past(mem_rsp_valid) && $past(mem_rsp_data[LF_BIT])));
  p_start_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_cause_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fault ? ($countones(fault_cause) == 1) : (fault_cause == 2'b00)));
  p_req_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
endmodule

// File: tb/radix_walker_tb.sv
`timescale 1ns/1ps
module radix_walker_tb;
  localparam logic [63:0] NLB = 64'h00FF_FFFF_FFFF_FF00;
  localparam logic [63:0] RPN = 64'h00FF_FFFF_FFFF_F000;
  localparam logic [63:0] T0 = 64'h10000, L1 = 64'h200000, L2 = 64'h300000,
                          L3 = 64'h400000, L4 = 64'h500000;

  logic clk = 0, rst_n = 0, start = 0;
  logic [63:0] va = 0, root_base = 0;
  logic [4:0]  root_nls = 0;
  logic [6:0]  total_size = 0;
  logic mem_req, mem_rsp_valid = 0;
  logic [63:0] mem_addr, mem_rsp_data = 0;
  logic busy, done, fault;
  logic [1:0] fault_cause;
  logic [63:0] real_addr, leaf_pte, pte_addr;
  logic [6:0] page_size;

  int checks = 0, errors = 0;
  logic [63:0] mem [logic [63:0]];
  bit pend = 0;
  logic [63:0] pa = 0;

  bit e_fault; logic [1:0] e_cause; logic [63:0] e_ra, e_pte, e_pa; int e_ps, e_n;

  always #4 clk = ~clk;

  radix_walker u_dut (.clk, .rst_n, .start, .va, .root_base, .root_nls, .total_size,
    .mem_req, .mem_addr, .mem_rsp_valid, .mem_rsp_data, .busy, .done, .fault,
    .fault_cause, .real_addr, .page_size, .leaf_pte, .pte_addr);

  always @(negedge clk) begin
    if (mem_rsp_valid) mem_rsp_valid = 0;
    if (pend) begin
      mem_rsp_valid = 1;
      mem_rsp_data = mem.exists(pa) ? mem[pa] : 64'd0;
      pend = 0;
    end
    if (mem_req) begin pend = 1; pa = mem_addr; end
  end

  function automatic logic [63:0] ent(input logic [63:0] b, input int n, input int p, input logic [63:0] v);
    logic [63:0] al = b & ~((64'd1 << (n + 3)) - 1);
    return al + (((v >> (p - n)) & ((64'd1 << n) - 1)) * 8);
  endfunction
  function automatic logic [63:0] pde(input logic [63:0] b, input int n);
    return 64'h8000_0000_0000_0000 | (b & NLB) | 64'(n);
  endfunction
  function automatic logic [63:0] lf(input logic [63:0] r);
    return 64'hC000_0000_0000_0000 | r;
  endfunction

  task automatic ref_walk(input logic [63:0] v, input logic [63:0] b, input int n, input int s);
    int p = s, lvl = 0;
    logic [63:0] a = ent(b, n, s, v), e, m;
    bit ok;
    e_fault = 0; e_cause = 0;
    forever begin
      ok = (lvl == 0) ? (p == 52 && n == 13) : (lvl <= 2) ? (n == 9) :
           (lvl == 3) ? (n == 9 || n == 5) : 0;
      if (!ok) begin e_fault = 1; e_cause = 2'b10; e_n = 2 * lvl + 1; return; end
      e = mem.exists(a) ? mem[a] : 64'd0;
      e_n = 2 * (lvl + 1);
      if (!e[63]) begin e_fault = 1; e_cause = 2'b01; return; end
      p = p - n;
      if (e[62]) begin
        m = (64'd1 << p) - 1;
        e_ra = (e & RPN & ~m) | (v & m); e_ps = p; e_pte = e; e_pa = a;
        return;
      end
      n = int'(e[4:0]);
      a = ent(e & NLB, n, p, v);
      lvl++;
    end
  endtask

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic go(input logic [63:0] v, input logic [63:0] b, input int n, input int s,
                    input bit intrude, input string rq);
    ref_walk(v, b, n, s);
    @(negedge clk);
    va = v; root_base = b; root_nls = 5'(n); total_size = 7'(s); start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 0; k <= e_n; k++) begin
      if (k > 0) @(negedge clk);
      if (intrude && k == 2) begin start = 1; va = ~v; root_base = 64'h0; end
      if (intrude && k == 3) start = 0;
      chk(done === (k == e_n) && busy === (k < e_n), "R10", "done/busy schedule",
          {62'd0, done, busy}, {62'd0, k == e_n, k < e_n});
    end
    chk(fault === e_fault && fault_cause === e_cause, e_fault ? rq : "R9", "fault/cause",
        {61'd0, fault, fault_cause}, {61'd0, e_fault, e_cause});
    if (!e_fault) begin
      chk(real_addr === e_ra, "R6", "real_addr", real_addr, e_ra);
      chk(page_size === 7'(e_ps), "R7", "page_size", 64'(page_size), 64'(e_ps));
      chk(leaf_pte === e_pte, "R6", "leaf_pte", leaf_pte, e_pte);
      chk(pte_addr === e_pa, rq, "pte_addr R1", pte_addr, e_pa);
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!done && !mem_req && !busy, "R8", "idle after walk",
          {61'd0, done, mem_req, busy}, 64'd0);
    end
  endtask

  task automatic tree4(input logic [63:0] v, input int last_n, input int leaf_lvl);
    mem.delete();
    mem[ent(T0, 13, 52, v)] = (leaf_lvl == 0) ? lf(64'h0) : pde(L1, 9);
    mem[ent(L1, 9, 39, v)]  = pde(L2, 9);
    if (leaf_lvl == 2) mem[ent(L2, 9, 30, v)] = lf(64'h0000_00AB_CDE0_01FF);
    else begin
      mem[ent(L2, 9, 30, v)] = pde(L3, last_n);
      mem[ent(L3, last_n, 21, v)] = lf(64'h0000_1234_5678_9ABC);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    chk(!done && !busy && !mem_req, "R9", "reset state", {61'd0, done, busy, mem_req}, 64'd0);
    rst_n = 1;

    v = 64'h000A_5A5A_1234_5678;
    tree4(v, 9, 3);  go(v, T0, 13, 52, 0, "R5");
    v = 64'h0003_C0FF_EE00_0ABC;
    tree4(v, 9, 3);  go(v, T0, 13, 52, 1, "R8");
    v = 64'h000F_1357_9BDF_2468;
    tree4(v, 9, 2);  go(v, T0, 13, 52, 0, "R7");
    tree4(v, 5, 3);  go(v, T0, 13, 52, 0, "R3");
    mem.delete(); mem[ent(T0, 13, 52, v)] = pde(L1, 9);
    go(v, T0, 13, 52, 0, "R4");
    go(v, T0, 12, 52, 0, "R3");
    go(v, T0, 13, 48, 0, "R3");
    mem.delete(); mem[ent(T0, 13, 52, v)] = pde(L1, 8);
    go(v, T0, 13, 52, 0, "R3");
    tree4(v, 9, 3);  go(v, T0 | 64'h1238, 13, 52, 0, "R2");
    mem.delete();
    mem[ent(T0, 13, 52, v)] = pde(L1 | 64'h700, 9);
    mem[ent(L1, 9, 39, v)]  = lf(64'h0000_0777_0000_0000);
    go(v, T0, 13, 52, 0, "R2");
    tree4(v, 9, 3); mem[ent(L3, 9, 21, v)] = pde(L4, 9);
    go(v, T0, 13, 52, 0, "R3");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule